// File: doc/BRIEF.md
# Two-Codeword Iteration Scheduler for a Partial-Parallel LDPC Decoder

This block is the sequencing controller of a partial-parallel LDPC decoder that keeps two codewords in flight at once. After a start, it loads the channel values of codeword A and then those of codeword B. From then on it gives the check-node array to one codeword and the bit-node array to the other, and swaps them after every phase. Once both codewords are streaming, neither array is left idle. A phase lasts `PHASE_CYC` cycles (default 2), and one iteration of a codeword is one check phase followed by one bit phase.

Each codeword has its own iteration counter and its own sticky done flag. A codeword retires when it has completed `MAX_ITER` iterations (default 10). It can also retire early if its parity-satisfied input is high in the last cycle of one of its bit phases. Without early exits, a pair of codewords takes 2 + 2 + 10×4 = 44 cycles. The surrounding datapath uses the enables and codeword selects to steer its memories, and uses the sub-cycle index to address the half of the block column it works on.

Top module: `ldpc_pair_sched`

## Requirements
- R1: After a synchronous reset the block is idle. `busy`, every enable, every select, `sub_idx`, both iteration counts and both done flags are 0.
- R2: `start` is acted on only while `busy` is 0. A `start` pulse while busy changes no output.
- R3: Count cycle 0 as the first cycle after the edge that accepted `start`. In cycles 0–1 `load_en`=1 and `load_cw`=0 (codeword A). In cycles 2–3 `load_en`=1 and `load_cw`=1 (codeword B). At all other times `load_en`=0 and `load_cw`=0.
- R4: Codeword A holds the check array in cycles 2–3 and the bit array in cycles 4–5, and repeats this every 4 cycles. Codeword B follows the same pattern 2 cycles later, starting with check in cycles 4–5. `chk_cw` and `bit_cw` are 0 for A and 1 for B, and each is 0 whenever its enable is 0.
- R5: While both codewords are active and past loading, `chk_en` and `bit_en` are both 1 in every cycle and name different codewords.
- R6: While busy, `sub_idx` counts 0,1 within each 2-cycle phase, starting at 0 in cycle 0. While idle it is 0.
- R7: A codeword's iteration count rises by 1 at the end of each of its bit phases and never exceeds `MAX_ITER`.
- R8: With no parity indication, `done_a` rises in cycle 42, `done_b` rises in cycle 44, and `busy` falls in cycle 44.
- R9: A parity-satisfied input is sampled only in the last cycle of its codeword's bit phase. At any other time it has no effect.
- R10: If parity is seen at the end of a codeword's bit phase for iteration N, that codeword stops: its done flag rises in the next cycle, its count stays at N, and it gets no further array slots. The other codeword's schedule is unchanged.
- R11: Done flags and iteration counts hold after the run until the next accepted `start`, which clears them in cycle 0.
- R12: A reset asserted in the middle of a run returns the block to the idle state of R1 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a pair run (ignored while busy) |
| parity_ok_a | input | 1 | Codeword A satisfies all checks |
| parity_ok_b | input | 1 | Codeword B satisfies all checks |
| busy | output | 1 | At least one codeword still in progress |
| load_en | output | 1 | Channel-value load slot |
| load_cw | output | 1 | Codeword being loaded (0 = A, 1 = B) |
| chk_en | output | 1 | Check-node array enabled |
| chk_cw | output | 1 | Codeword on the check array |
| bit_en | output | 1 | Bit-node array enabled |
| bit_cw | output | 1 | Codeword on the bit array |
| sub_idx | output | 1 | Cycle index inside the current phase |
| iter_a | output | 4 | Completed iterations of codeword A |
| iter_b | output | 4 | Completed iterations of codeword B |
| done_a | output | 1 | Codeword A finished (sticky) |
| done_b | output | 1 | Codeword B finished (sticky) |

## Verification
All outputs are decoded from registers, so every scheduling output for cycle k is a pure function of k and of the iteration at which each codeword retires. The bench drives each input half a cycle ahead and compares every output at the falling edge of each cycle against closed-form expressions. A parity input sampled in cycle 4N+1 (A) or 4N+3 (B) changes the counter and the done flag one cycle later, in cycles 4N+2 and 4N+4. Reset and a start while busy are checked in the first cycle after the edge that sees them.

// File: rtl/ldpc_sched_pkg.sv
package ldpc_sched_pkg;

    // codeword identity as carried on the select outputs
    typedef enum logic {
        CW_A = 1'b0,
        CW_B = 1'b1
    } cw_e;

    // number of load slots ahead of the interleaved phases (one per codeword)
    localparam int LOAD_SLOTS = 2;

endpackage

// File: rtl/sched_slot_timer.sv
module sched_slot_timer #(
    parameter  int PHASE_CYC = 2,
    parameter  int SLOT_CNT  = 22,
    localparam int SUB_W     = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1,
    localparam int SLOT_W    = $clog2(SLOT_CNT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              run,
    output logic [SUB_W-1:0]  sub,
    output logic [SLOT_W-1:0] slot,
    output logic              sub_last
);

    typedef struct packed {
        logic [SUB_W-1:0]  sub;
        logic [SLOT_W-1:0] slot;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    localparam logic [SUB_W-1:0]  SUB_END  = SUB_W'(PHASE_CYC - 1);
    localparam logic [SLOT_W-1:0] SLOT_END = SLOT_W'(SLOT_CNT - 1);

    always_comb begin
        tmr_d = tmr_q;
        if (launch) begin
            tmr_d.sub  = '0;
            tmr_d.slot = '0;
        end else if (run) begin
            if (tmr_q.sub == SUB_END) begin
                tmr_d.sub = '0;
                if (tmr_q.slot != SLOT_END)
                    tmr_d.slot = tmr_q.slot + 1'b1;
            end else begin
                tmr_d.sub = tmr_q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tmr_q <= '0;
        else     tmr_q <= tmr_d;
    end

    assign sub      = tmr_q.sub;
    assign slot     = tmr_q.slot;
    assign sub_last = (tmr_q.sub == SUB_END);

    AST_SUB_RANGE: assert property (@(posedge clk) disable iff (rst)
        tmr_q.sub <= SUB_END);                                         // R6

endmodule

// File: rtl/sched_cw_track.sv
module sched_cw_track #(
    parameter  int MAX_ITER   = 10,
    parameter  int FIRST_SLOT = 1,
    parameter  int SLOT_W     = 5,
    localparam int ITER_W     = $clog2(MAX_ITER + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [SLOT_W-1:0] slot,
    input  logic              sub_last,
    input  logic              parity_ok,
    output logic              chk_on,
    output logic              bit_on,
    output logic              active,
    output logic              done,
    output logic [ITER_W-1:0] iter
);

    typedef struct packed {
        logic              active;
        logic              done;
        logic [ITER_W-1:0] iter;
    } cw_t;

    cw_t cw_d, cw_q;

    localparam logic [SLOT_W-1:0] FIRST    = SLOT_W'(FIRST_SLOT);
    localparam logic [ITER_W-1:0] LAST_IT  = ITER_W'(MAX_ITER - 1);
    localparam logic [ITER_W-1:0] ITER_CAP = ITER_W'(MAX_ITER);

    logic              in_win;
    logic [SLOT_W-1:0] rel;

    always_comb begin
        rel    = slot - FIRST;
        in_win = cw_q.active && (slot >= FIRST);
        chk_on = in_win && !rel[0];
        bit_on = in_win &&  rel[0];

        cw_d = cw_q;
        if (launch) begin
            cw_d.active = 1'b1;
            cw_d.done   = 1'b0;
            cw_d.iter   = '0;
        end else if (bit_on && sub_last) begin
            cw_d.iter = cw_q.iter + 1'b1;
            if (parity_ok || cw_q.iter == LAST_IT) begin
                cw_d.active = 1'b0;
                cw_d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cw_q <= '0;
        else     cw_q <= cw_d;
    end

    assign active = cw_q.active;
    assign done   = cw_q.done;
    assign iter   = cw_q.iter;

    AST_ITER_CAP: assert property (@(posedge clk) disable iff (rst)
        cw_q.iter <= ITER_CAP);                                        // R7

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        cw_q.done && !launch |=> cw_q.done);                           // R11

    AST_RETIRE_AT_PHASE_END: assert property (@(posedge clk) disable iff (rst)
        !cw_q.done && !launch |=> cw_q.done -> $past(bit_on && sub_last)); // R10

    AST_DONE_NOT_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        cw_q.done |-> !cw_q.active);                                   // R8

endmodule

// File: rtl/ldpc_pair_sched.sv
module ldpc_pair_sched #(
    parameter  int PHASE_CYC = 2,
    parameter  int MAX_ITER  = 10,
    localparam int SUB_W     = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1,
    localparam int ITER_W    = $clog2(MAX_ITER + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              parity_ok_a,
    input  logic              parity_ok_b,
    output logic              busy,
    output logic              load_en,
    output logic              load_cw,
    output logic              chk_en,
    output logic              chk_cw,
    output logic              bit_en,
    output logic              bit_cw,
    output logic [SUB_W-1:0]  sub_idx,
    output logic [ITER_W-1:0] iter_a,
    output logic [ITER_W-1:0] iter_b,
    output logic              done_a,
    output logic              done_b
);
    import ldpc_sched_pkg::*;

    localparam int SLOT_CNT = ldpc_sched_pkg::LOAD_SLOTS + 2 * MAX_ITER;
    localparam int SLOT_W   = $clog2(SLOT_CNT);

    logic              launch;
    logic [SUB_W-1:0]  sub_w;
    logic [SLOT_W-1:0] slot_w;
    logic              sub_last_w;

    logic [1:0]        par_v, chk_on_v, bit_on_v, act_v, done_v;
    logic [ITER_W-1:0] iter_v [2];

    assign par_v  = {parity_ok_b, parity_ok_a};
    assign busy   = |act_v;
    assign launch = start && !busy;

    sched_slot_timer #(
        .PHASE_CYC (PHASE_CYC),
        .SLOT_CNT  (SLOT_CNT)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .launch   (launch),
        .run      (busy),
        .sub      (sub_w),
        .slot     (slot_w),
        .sub_last (sub_last_w)
    );

    // codeword g starts its first check phase in slot 1+g
    for (genvar g = 0; g < 2; g++) begin : g_cw
        sched_cw_track #(
            .MAX_ITER   (MAX_ITER),
            .FIRST_SLOT (1 + g),
            .SLOT_W     (SLOT_W)
        ) u_track (
            .clk       (clk),
            .rst       (rst),
            .launch    (launch),
            .slot      (slot_w),
            .sub_last  (sub_last_w),
            .parity_ok (par_v[g]),
            .chk_on    (chk_on_v[g]),
            .bit_on    (bit_on_v[g]),
            .active    (act_v[g]),
            .done      (done_v[g]),
            .iter      (iter_v[g])
        );
    end

    always_comb begin
        load_en = busy && (slot_w < SLOT_W'(ldpc_sched_pkg::LOAD_SLOTS));
        load_cw = load_en && slot_w[0];
        chk_en  = |chk_on_v;
        chk_cw  = chk_on_v[CW_B];
        bit_en  = |bit_on_v;
        bit_cw  = bit_on_v[CW_B];
        sub_idx = busy ? sub_w : '0;
        iter_a  = iter_v[0];
        iter_b  = iter_v[1];
        done_a  = done_v[0];
        done_b  = done_v[1];
    end

    AST_ARRAYS_DISJOINT: assert property (@(posedge clk) disable iff (rst)
        chk_en && bit_en |-> chk_cw != bit_cw);                        // R5

    AST_LOAD_NO_BIT: assert property (@(posedge clk) disable iff (rst)
        load_en |-> !bit_en);                                          // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(chk_en || bit_en || load_en));                     // R1

    AST_START_BUSY_IGNORED: assert property (@(posedge clk) disable iff (rst)
        start && busy && $past(busy) |=> !(sub_w == '0 && slot_w == '0)); // R2

endmodule

// File: tb/sim_ldpc_pair_sched.sv
module sim_ldpc_pair_sched;

    logic clk = 1'b0;
    logic rst, start, parity_ok_a, parity_ok_b;
    logic busy, load_en, load_cw, chk_en, chk_cw, bit_en, bit_cw;
    logic [0:0] sub_idx;
    logic [3:0] iter_a, iter_b;
    logic done_a, done_b;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ldpc_pair_sched u0 (
        .clk(clk), .rst(rst), .start(start),
        .parity_ok_a(parity_ok_a), .parity_ok_b(parity_ok_b),
        .busy(busy), .load_en(load_en), .load_cw(load_cw),
        .chk_en(chk_en), .chk_cw(chk_cw), .bit_en(bit_en), .bit_cw(bit_cw),
        .sub_idx(sub_idx), .iter_a(iter_a), .iter_b(iter_b),
        .done_a(done_a), .done_b(done_b)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(string req);
        chk(req, "busy", busy, 0);
        chk(req, "load_en", load_en, 0);
        chk(req, "chk_en", chk_en, 0);
        chk(req, "bit_en", bit_en, 0);
        chk(req, "chk_cw", chk_cw, 0);
        chk(req, "bit_cw", bit_cw, 0);
        chk(req, "sub_idx", sub_idx, 0);
        chk(req, "iter_a", iter_a, 0);
        chk(req, "iter_b", iter_b, 0);
        chk(req, "done_a", done_a, 0);
        chk(req, "done_b", done_b, 0);
    endtask

    // na / nb: iteration at which each codeword retires (10 = no early exit)
    task automatic run(int na, int nb, bit noise, bit poke, string rq);
        int ea = 4 * na + 2;
        int eb = 4 * nb + 4;
        int e  = (ea > eb) ? ea : eb;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int k = 0; k <= e + 3; k++) begin
            int  slot = k / 2;
            int  sub  = k % 2;
            bit  dA   = (k >= ea);
            bit  dB   = (k >= eb);
            bit  bz   = !(dA && dB);
            bit  aW   = !dA && slot >= 1;
            bit  bW   = !dB && slot >= 2;
            bit  aH   = ((slot - 1) % 2) == 0;
            bit  bH   = ((slot - 2) % 2) == 0;
            bit  cE   = (aW && aH) || (bW && bH);
            bit  cC   = bW && bH;
            bit  vE   = (aW && !aH) || (bW && !bH);
            bit  vC   = bW && !bH;
            bit  lE   = bz && slot < 2;
            int  iA   = (k >= 6) ? (k - 6) / 4 + 1 : 0;
            int  iB   = (k >= 8) ? (k - 8) / 4 + 1 : 0;
            if (iA > na) iA = na;
            if (iB > nb) iB = nb;
            if (noise) begin
                // R9: high everywhere except the A / B sampling cycles
                parity_ok_a = (k % 4) != 1;
                parity_ok_b = (k % 4) != 3;
            end else begin
                parity_ok_a = (na < 10) && (k == 4 * na + 1);
                parity_ok_b = (nb < 10) && (k == 4 * nb + 3);
            end
            start = poke && (k == 10);   // R2: ignored mid-run
            chk("R8", "busy", busy, bz);
            chk("R3", "load_en", load_en, lE);
            chk("R3", "load_cw", load_cw, lE && slot == 1);
            chk("R4", "chk_en", chk_en, cE);
            chk("R4", "chk_cw", chk_cw, cC);
            chk("R4", "bit_en", bit_en, vE);
            chk("R4", "bit_cw", bit_cw, vC);
            if (aW && bW) chk("R5", "both_arrays", chk_en && bit_en, 1);
            chk("R6", "sub_idx", sub_idx, bz ? sub : 0);
            chk("R7", "iter_a", iter_a, iA);
            chk("R7", "iter_b", iter_b, iB);
            chk(rq, "done_a", done_a, dA);
            chk(rq, "done_b", done_b, dB);
            if (k > e) chk("R11", "hold_iter_a", iter_a, na);
            @(negedge clk);
        end
        parity_ok_a = 1'b0;
        parity_ok_b = 1'b0;
        start       = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; parity_ok_a = 1'b0; parity_ok_b = 1'b0;
        repeat (3) @(negedge clk);
        chk_idle("R1");
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R1");

        run(10, 10, 1'b0, 1'b0, "R8");     // full 44-cycle run
        run(10, 10, 1'b0, 1'b1, "R2");     // start while busy
        run(10, 10, 1'b1, 1'b0, "R9");     // parity outside sampling cycle
        for (int n = 1; n <= 9; n++) run(n, 10, 1'b0, 1'b0, "R10");
        for (int n = 1; n <= 9; n++) run(10, n, 1'b0, 1'b0, "R10");
        run(1, 1, 1'b0, 1'b0, "R10");
        run(3, 7, 1'b0, 1'b0, "R10");
        run(10, 2, 1'b0, 1'b0, "R10");

        // R12: reset in the middle of a run
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (15) @(negedge clk);
        rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        chk_idle("R12");
        run(2, 5, 1'b0, 1'b0, "R11");      // restart clears prior state

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule